// File: doc/BRIEF.md
# Masked Ternary Key Search Engine

This block is a compact ternary lookup table. It holds `DEPTH` entries, and each entry is 144 bits wide with its own 144-bit local mask. A host starts a lookup with a two-cycle command on a 72-bit data bus. The first cycle carries the lower half of the key and picks one of eight global mask pairs. The second cycle carries the upper half of the key. It also names a comparand register to keep the full key and a result register to record the outcome.

The key is compared against every entry at once. A bit position counts as matching when the key bit equals the stored bit, or when either the global mask or the entry's local mask is 0 there. The lowest-indexed matching entry wins. Its location address is reported as twice the entry index, because each entry fills an even/odd pair of locations.

The result flows through a fixed pipeline. The address reaches the SRAM-address output `SADR_LAT` cycles after the first command cycle. A one-cycle status strobe and its hit flag follow after a further 0 to 3 cycles, set by `xlat`. A plain write port loads entries and global mask pairs.

A small state machine decodes the commands. It has two states:
- `ST_WAIT_A` waits for the first command cycle.
- `ST_WAIT_B` expects the second command cycle.

It has two transitions:
- A_TO_B is taken on a valid search opcode in `ST_WAIT_A`.
- B_TO_A is always taken from `ST_WAIT_B`. It issues the search only when that cycle also carries a valid search opcode; otherwise the command is dropped.

Top module: `tcam_search_engine`

## Requirements
- R1: A search is `cmdv`=1 with `cmd[1:0]`=2'b10 in two consecutive cycles. The `dq` value of the first cycle is key[71:0] and the `dq` value of the second cycle is key[143:72]. If the second cycle lacks valid or the opcode, the search is dropped: no status pulse and no register update.
- R2: `cmd[4:2]` in the first cycle selects one of 8 global mask pairs. A global mask bit of 0 makes that key position match regardless of the data.
- R3: An entry matches when every bit position has equal key and entry data, or has a 0 local mask bit (1 = compare, 0 = ignore).
- R4: When several entries match, the lowest index wins. The reported address is 2*index, so address bit 0 is always 0.
- R5: `cmd[5:2]` in the second cycle selects one of 16 comparand registers that stores the full 144-bit key. It is readable on `cmp_data` through `cmp_sel`.
- R6: `cmd[8:6]` in the second cycle selects one of 8 result registers. That register records the hit flag and the address, with address 0 on a miss. It is readable through `res_sel`.
- R7: On a hit, `sadr` takes the winning address exactly 6 cycles after the first command cycle is sampled. On a miss, `sadr` keeps its previous value.
- R8: `ssv` pulses for one cycle exactly 6+`xlat` cycles after the first command cycle, for every search, hit or miss. `ssf` equals the hit flag in that cycle and is 0 at all other times.
- R9: At most one search completes every two cycles. A new first cycle may directly follow a second cycle, so searches can run back to back.
- R10: With `wr_en`=1 and `wr_gmask`=0, `wr_data` and `wr_mask` load entry `wr_idx`. With `wr_gmask`=1, `wr_mask` loads global mask pair `wr_idx[2:0]`. A write sampled with a search's first cycle is seen by that search. A write sampled with its second cycle is seen only by later searches.
- R11: After reset:
  - all entries hold data 0 with an all-ones mask;
  - all global masks are all ones;
  - comparand and result registers are 0;
  - `sadr`, `ssv` and `ssf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdv | input | 1 | Command valid |
| cmd | input | 9 | Command field: opcode and indexes |
| dq | input | 72 | Key half for the current command cycle |
| xlat | input | 2 | Extra status latency, 0 to 3 cycles |
| wr_en | input | 1 | Write strobe |
| wr_gmask | input | 1 | 1 = write a global mask pair, 0 = write an entry |
| wr_idx | input | 6 | Entry index, or global pair index in bits [2:0] |
| wr_data | input | 144 | Entry data |
| wr_mask | input | 144 | Entry local mask or global mask value |
| cmp_sel | input | 4 | Comparand register read select |
| cmp_data | output | 144 | Selected comparand register |
| res_sel | input | 3 | Result register read select |
| res_hit | output | 1 | Hit flag of the selected result register |
| res_addr | output | 7 | Address of the selected result register |
| sadr | output | 7 | SRAM address of the last winning entry |
| ssv | output | 1 | Search status valid strobe |
| ssf | output | 1 | Search hit flag |

## Verification
Two events can fall in the same cycle:
- A table write and the second cycle of a search. The bench provokes this by loading the very key being searched into an entry on that edge. The search must still miss, and the next identical search must hit. The same write placed on the first command cycle must be seen at once.
- The second cycle of one search and the first cycle of the next, in back-to-back bursts. Here every status strobe, every address update and every result register is compared cycle by cycle with a behavioural queue model.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int CMD_W      = 9;
    localparam int GM_IDX_W   = 3;
    localparam int CMP_IDX_W  = 4;
    localparam int RES_IDX_W  = 3;
    localparam int XLAT_W     = 2;
    localparam int XLAT_MAX   = 3;
    localparam logic [1:0] OP_SEARCH = 2'b10;

    typedef enum logic [0:0] {
        ST_WAIT_A = 1'b0,
        ST_WAIT_B = 1'b1
    } srch_state_e;
endpackage

// File: rtl/tcam_cmd_fsm.sv
module tcam_cmd_fsm
    import tcam_pkg::*;
#(
    parameter int HALF_W = 72
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmdv,
    input  logic [CMD_W-1:0]      cmd,
    input  logic [HALF_W-1:0]     dq,
    output logic                  issue,
    output logic [2*HALF_W-1:0]   key,
    output logic [GM_IDX_W-1:0]   gm_idx,
    output logic [CMP_IDX_W-1:0]  cmp_idx,
    output logic [RES_IDX_W-1:0]  res_idx
);
    srch_state_e state, state_nx;
    logic [HALF_W-1:0]   even_q;
    logic [GM_IDX_W-1:0] gm_q;
    logic                is_srch;

    assign is_srch = cmdv && (cmd[1:0] == OP_SEARCH);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_A;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        issue    = 1'b0;
        unique case (state)
            ST_WAIT_A: if (is_srch) state_nx = ST_WAIT_B;      // A_TO_B
            ST_WAIT_B: begin                                   // B_TO_A
                state_nx = ST_WAIT_A;
                issue    = is_srch;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q <= '0;
            gm_q   <= '0;
        end else if (state == ST_WAIT_A && is_srch) begin
            even_q <= dq;
            gm_q   <= cmd[2+GM_IDX_W-1:2];
        end
    end

    assign key     = {dq, even_q};
    assign gm_idx  = gm_q;
    assign cmp_idx = cmd[2+CMP_IDX_W-1:2];
    assign res_idx = cmd[CMD_W-1:CMD_W-RES_IDX_W];

    AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);                                              // R9
    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> $past(is_srch));                                      // R1
endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
    parameter int DEPTH = 64,
    parameter int KEY_W = 144
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [KEY_W-1:0]         wr_data,
    input  logic [KEY_W-1:0]         wr_mask,
    input  logic [KEY_W-1:0]         key,
    input  logic [KEY_W-1:0]         gmask,
    output logic [DEPTH-1:0]         match_vec
);
    localparam int IDX_W = $clog2(DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [KEY_W-1:0] e_data;
        logic [KEY_W-1:0] e_mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_data <= '0;
                e_mask <= '1;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                e_data <= wr_data;
                e_mask <= wr_mask;
            end
        end

        assign match_vec[g] = ~|((key ^ e_data) & e_mask & gmask);
    end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int DEPTH = 64
) (
    input  logic [DEPTH-1:0]         vec,
    output logic                     hit,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int IDX_W = $clog2(DEPTH);

    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tcam_search_engine.sv
module tcam_search_engine
    import tcam_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HALF_W   = 72,
    parameter int SADR_LAT = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmdv,
    input  logic [CMD_W-1:0]           cmd,
    input  logic [HALF_W-1:0]          dq,
    input  logic [XLAT_W-1:0]          xlat,
    input  logic                       wr_en,
    input  logic                       wr_gmask,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic [2*HALF_W-1:0]        wr_data,
    input  logic [2*HALF_W-1:0]        wr_mask,
    input  logic [CMP_IDX_W-1:0]       cmp_sel,
    output logic [2*HALF_W-1:0]        cmp_data,
    input  logic [RES_IDX_W-1:0]       res_sel,
    output logic                       res_hit,
    output logic [$clog2(DEPTH):0]     res_addr,
    output logic [$clog2(DEPTH):0]     sadr,
    output logic                       ssv,
    output logic                       ssf
);
    localparam int KEY_W  = 2 * HALF_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int ADDR_W = IDX_W + 1;
    localparam int GM_N   = 1 << GM_IDX_W;
    localparam int CMP_N  = 1 << CMP_IDX_W;
    localparam int RES_N  = 1 << RES_IDX_W;
    localparam int PIPE_N = SADR_LAT - 2 + XLAT_MAX;  // stages 2 .. SADR_LAT-1+XLAT_MAX
    localparam int SADR_TAP = SADR_LAT - 3;

    logic                 issue;
    logic [KEY_W-1:0]     key;
    logic [GM_IDX_W-1:0]  gm_idx;
    logic [CMP_IDX_W-1:0] cmp_idx;
    logic [RES_IDX_W-1:0] res_idx;
    logic [KEY_W-1:0]     gm_regs  [GM_N];
    logic [KEY_W-1:0]     cmp_regs [CMP_N];
    logic                 rr_hit   [RES_N];
    logic [ADDR_W-1:0]    rr_addr  [RES_N];
    logic [DEPTH-1:0]     match_vec, mv_q;
    logic                 s1_vld;
    logic [RES_IDX_W-1:0] s1_res;
    logic                 pe_hit;
    logic [IDX_W-1:0]     pe_idx;
    logic                 pv [PIPE_N];
    logic                 ph [PIPE_N];
    logic [ADDR_W-1:0]    pa [PIPE_N];

    tcam_cmd_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmdv(cmdv), .cmd(cmd), .dq(dq),
        .issue(issue), .key(key), .gm_idx(gm_idx),
        .cmp_idx(cmp_idx), .res_idx(res_idx)
    );

    tcam_match_array #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_gmask),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
        .key(key), .gmask(gm_regs[gm_idx]), .match_vec(match_vec)
    );

    tcam_prio_enc #(.DEPTH(DEPTH)) u_pe (
        .vec(mv_q), .hit(pe_hit), .idx(pe_idx)
    );

    // global mask pairs
    for (genvar g = 0; g < GM_N; g++) begin : g_gm
        always_ff @(posedge clk) begin
            if (!rst_n) gm_regs[g] <= '1;
            else if (wr_en && wr_gmask && wr_idx[GM_IDX_W-1:0] == GM_IDX_W'(g))
                gm_regs[g] <= wr_mask;
        end
    end

    // stage 1: capture match vector and store comparand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_q   <= '0;
            s1_vld <= 1'b0;
            s1_res <= '0;
        end else begin
            s1_vld <= issue;
            if (issue) begin
                mv_q   <= match_vec;
                s1_res <= res_idx;
            end
        end
    end

    for (genvar c = 0; c < CMP_N; c++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n) cmp_regs[c] <= '0;
            else if (issue && cmp_idx == CMP_IDX_W'(c)) cmp_regs[c] <= key;
        end
    end

    // stage 2: priority result into the delay pipe and the result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv[0] <= 1'b0;
            ph[0] <= 1'b0;
            pa[0] <= '0;
        end else begin
            pv[0] <= s1_vld;
            ph[0] <= s1_vld && pe_hit;
            pa[0] <= pe_hit ? {pe_idx, 1'b0} : '0;
        end
    end

    for (genvar r = 0; r < RES_N; r++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rr_hit[r]  <= 1'b0;
                rr_addr[r] <= '0;
            end else if (s1_vld && s1_res == RES_IDX_W'(r)) begin
                rr_hit[r]  <= pe_hit;
                rr_addr[r] <= pe_hit ? {pe_idx, 1'b0} : '0;
            end
        end
    end

    for (genvar j = 1; j < PIPE_N; j++) begin : g_pipe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pv[j] <= 1'b0;
                ph[j] <= 1'b0;
                pa[j] <= '0;
            end else begin
                pv[j] <= pv[j-1];
                ph[j] <= ph[j-1];
                pa[j] <= pa[j-1];
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sadr <= '0;
            ssv  <= 1'b0;
            ssf  <= 1'b0;
        end else begin
            if (pv[SADR_TAP] && ph[SADR_TAP]) sadr <= pa[SADR_TAP];
            ssv <= pv[SADR_TAP + int'(xlat)];
            ssf <= pv[SADR_TAP + int'(xlat)] && ph[SADR_TAP + int'(xlat)];
        end
    end

    assign cmp_data = cmp_regs[cmp_sel];
    assign res_hit  = rr_hit[res_sel];
    assign res_addr = rr_addr[res_sel];

    logic [DEPTH-1:0] below_win;
    assign below_win = ({{(DEPTH-1){1'b0}}, 1'b1} << pa[0][ADDR_W-1:1]) - 1'b1;

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        sadr[0] == 1'b0);                                               // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pv[0] && ph[0]) |-> (mv_q[pa[0][ADDR_W-1:1]] && ((mv_q & below_win) == '0))); // R4
    AST_FLAG_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ssf |-> ssv);                                                   // R8
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(pv[SADR_TAP] && ph[SADR_TAP]) |=> $stable(sadr));             // R7
endmodule

// File: tb/sim_tcam_search_engine.sv
module sim_tcam_search_engine;
    localparam int DEPTH = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmdv = 1'b0;
    logic [8:0]   cmd = '0;
    logic [71:0]  dq = '0;
    logic [1:0]   xlat = '0;
    logic         wr_en = 1'b0;
    logic         wr_gmask = 1'b0;
    logic [5:0]   wr_idx = '0;
    logic [143:0] wr_data = '0;
    logic [143:0] wr_mask = '0;
    logic [3:0]   cmp_sel = '0;
    logic [143:0] cmp_data;
    logic [2:0]   res_sel = '0;
    logic         res_hit;
    logic [6:0]   res_addr;
    logic [6:0]   sadr;
    logic         ssv, ssf;

    always #2 clk = ~clk;   // 250 MHz

    tcam_search_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmdv(cmdv), .cmd(cmd), .dq(dq), .xlat(xlat),
        .wr_en(wr_en), .wr_gmask(wr_gmask), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_mask(wr_mask), .cmp_sel(cmp_sel), .cmp_data(cmp_data),
        .res_sel(res_sel), .res_hit(res_hit), .res_addr(res_addr),
        .sadr(sadr), .ssv(ssv), .ssf(ssf)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    logic [143:0] m_data [DEPTH];
    logic [143:0] m_mask [DEPTH];
    logic [143:0] m_gm   [8];
    logic [143:0] m_cmp  [16];
    logic         m_rhit [8];
    logic [6:0]   m_radr [8];
    logic         sch_v [16], sch_h [16];
    logic [6:0]   sch_a [16];
    logic         st_v [16], st_h [16];
    logic [6:0]   exp_sadr;
    logic         exp_ssv, exp_ssf;
    int           cyc;
    bit           m_inb;
    logic [71:0]  m_even;
    int           m_gsel;

    task automatic m_search(input logic [143:0] k, input int g,
                            output logic h, output logic [6:0] a);
        h = 0; a = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!h && (((k ^ m_data[i]) & m_mask[i] & m_gm[g]) == '0)) begin
                h = 1; a = 7'(2 * i);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_mask[i] = '1; end
            for (int i = 0; i < 8; i++) begin m_gm[i] = '1; m_rhit[i] = 0; m_radr[i] = '0; end
            for (int i = 0; i < 16; i++) begin
                m_cmp[i] = '0; sch_v[i] = 0; sch_h[i] = 0; sch_a[i] = '0; st_v[i] = 0; st_h[i] = 0;
            end
            exp_sadr = '0; exp_ssv = 0; exp_ssf = 0; cyc = 0; m_inb = 0;
        end else begin
            logic h; logic [6:0] a; logic [143:0] k; int s;
            cyc = cyc + 1;
            s = cyc % 16;
            if (sch_v[s] && sch_h[s]) exp_sadr = sch_a[s];
            exp_ssv = st_v[s]; exp_ssf = st_v[s] && st_h[s];
            sch_v[s] = 0; st_v[s] = 0;
            if (!m_inb) begin
                if (cmdv && cmd[1:0] == 2'b10) begin
                    m_even = dq; m_gsel = int'(cmd[4:2]); m_inb = 1;
                end
            end else begin
                m_inb = 0;
                if (cmdv && cmd[1:0] == 2'b10) begin
                    k = {dq, m_even};
                    m_search(k, m_gsel, h, a);
                    sch_v[(cyc + 5) % 16] = 1; sch_h[(cyc + 5) % 16] = h; sch_a[(cyc + 5) % 16] = a;
                    st_v[(cyc + 5 + int'(xlat)) % 16] = 1; st_h[(cyc + 5 + int'(xlat)) % 16] = h;
                    m_cmp[cmd[5:2]] = k;
                    m_rhit[cmd[8:6]] = h; m_radr[cmd[8:6]] = a;
                end
            end
            if (wr_en) begin
                if (wr_gmask) m_gm[wr_idx[2:0]] = wr_mask;
                else begin m_data[wr_idx] = wr_data; m_mask[wr_idx] = wr_mask; end
            end
        end
    end

    // ---------------- comparison helpers ----------------
    task automatic check(input string tag, input logic [143:0] act, input logic [143:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [6:0] prev_sadr = '0;
    int last_sadr_cyc = 0, last_ssv_cyc = 0, ssv_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 sadr per-cycle", 144'(sadr), 144'(exp_sadr));
            check("R8 ssv per-cycle", 144'(ssv), 144'(exp_ssv));
            check("R8 ssf per-cycle", 144'(ssf), 144'(exp_ssf));
            if (sadr !== prev_sadr) last_sadr_cyc = cyc;
            if (ssv) begin last_ssv_cyc = cyc; ssv_cnt++; end
            prev_sadr = sadr;
        end
    end

    task automatic chk_res(input string tag, input int sel, input logic h, input logic [6:0] a);
        res_sel = 3'(sel); #1;
        check({tag, " result hit"}, 144'(res_hit), 144'(h));
        check({tag, " result addr"}, 144'(res_addr), 144'(a));
        check({tag, " result vs model"}, 144'({res_hit, res_addr}), 144'({m_rhit[sel], m_radr[sel]}));
    endtask

    // ---------------- stimulus tasks ----------------
    function automatic logic [143:0] ent_d(input int i);
        return {72'(i * 3 + 7), ~72'(i)};
    endfunction

    int a_cyc;

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmdv = 0; cmd = '0; wr_en = 0; wr_gmask = 0;
        end
    endtask

    task automatic wr(input bit gm, input int idx, input logic [143:0] d, input logic [143:0] m);
        @(negedge clk);
        cmdv = 0; wr_en = 1; wr_gmask = gm; wr_idx = 6'(idx); wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic srch_x(input logic [143:0] k, input int gm, input int cs, input int rs,
                          input bit wa, input bit wb, input int widx, input logic [143:0] wd,
                          input bit abort_b);
        @(negedge clk);
        a_cyc = cyc + 1;
        cmdv = 1; cmd = {3'b000, 1'b0, 3'(gm), 2'b10}; dq = k[71:0];
        wr_en = wa; wr_gmask = 0; wr_idx = 6'(widx); wr_data = wd; wr_mask = '1;
        @(negedge clk);
        cmdv = !abort_b; cmd = {3'(rs), 4'(cs), 2'b10}; dq = k[143:72];
        wr_en = wb; wr_gmask = 0; wr_idx = 6'(widx); wr_data = wd; wr_mask = '1;
    endtask

    task automatic srch(input logic [143:0] k, input int gm, input int cs, input int rs);
        srch_x(k, gm, cs, rs, 0, 0, 0, '0, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [143:0] dk, k2;
        logic [6:0] hold;
        int cnt0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R11 reset state
        check("R11 sadr after reset", 144'(sadr), 144'(0));
        check("R11 ssv after reset", 144'(ssv), 144'(0));
        cmp_sel = 4'd9; #1;
        check("R11 comparand after reset", cmp_data, 144'(0));
        chk_res("R11", 3, 0, 7'd0);
        // R11: reset entry 0 holds zero data with full mask, so a zero key hits it
        srch('0, 0, 0, 0); idle(12);
        chk_res("R11 zero key", 0, 1, 7'd0);

        // load the table (R10)
        for (int i = 0; i < DEPTH; i++) wr(0, i, ent_d(i), '1);
        idle(2);

        // R1 basic search, R5 comparand, R6 result
        srch(ent_d(10), 0, 1, 2); idle(12);
        chk_res("R1", 2, 1, 7'd20);
        cmp_sel = 4'd1; #1;
        check("R5 comparand key", cmp_data, ent_d(10));
        check("R7 sadr after hit", 144'(sadr), 144'(20));
        check("R7 sadr latency", 144'(last_sadr_cyc - a_cyc), 144'(6));
        check("R8 ssv latency xlat0", 144'(last_ssv_cyc - a_cyc), 144'(6));

        // R4 lowest index wins
        wr(0, 50, ent_d(33), '1);
        srch(ent_d(33), 0, 2, 1); idle(12);
        chk_res("R4", 1, 1, 7'd66);

        // R3 local mask
        dk = 144'h1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0_FFFF;
        wr(0, 7, dk, ~144'hFF);
        srch(dk ^ 144'h0F, 0, 3, 3); idle(12);
        chk_res("R3 masked bits ignored", 3, 1, 7'd14);
        hold = sadr;
        srch(dk ^ (144'h1 << 8), 0, 3, 3); idle(12);
        chk_res("R6 miss records zero", 3, 0, 7'd0);
        check("R7 sadr holds on miss", 144'(sadr), 144'(hold));
        check("R8 ssv pulses on miss", 144'(last_ssv_cyc - a_cyc), 144'(6));

        // R2 global mask pair selection
        wr(1, 3, '0, {72'h0, {72{1'b1}}});
        k2 = {72'hDEAD_BEEF, ent_d(12)[71:0]};
        srch(k2, 3, 4, 4); idle(12);
        chk_res("R2 global pair ignores upper half", 4, 1, 7'd24);
        srch(k2, 0, 4, 4); idle(12);
        chk_res("R2 full global mask misses", 4, 0, 7'd0);

        // R8 extra latency
        xlat = 2'd3; idle(2);
        srch(ent_d(20), 0, 5, 5); idle(14);
        check("R8 ssv latency xlat3", 144'(last_ssv_cyc - a_cyc), 144'(9));
        check("R7 sadr latency unaffected by xlat", 144'(last_sadr_cyc - a_cyc), 144'(6));
        xlat = 2'd1; idle(2);

        // R9 back-to-back searches
        srch(ent_d(1), 0, 6, 0);
        srch(ent_d(2), 0, 7, 1);
        srch(ent_d(3), 0, 8, 6);
        idle(14);
        chk_res("R9 first", 0, 1, 7'd2);
        chk_res("R9 second", 1, 1, 7'd4);
        chk_res("R9 third", 6, 1, 7'd6);
        cmp_sel = 4'd7; #1;
        check("R9 comparand of second", cmp_data, ent_d(2));
        xlat = 2'd0; idle(2);

        // R10 write ordering against a search
        k2 = 144'hABCD_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        srch_x(k2, 0, 9, 4, 0, 1, 2, k2, 0); idle(12);
        chk_res("R10 write in cycle B not seen", 4, 0, 7'd0);
        srch(k2, 0, 9, 4); idle(12);
        chk_res("R10 write seen by next search", 4, 1, 7'd4);
        dk = 144'h5555_AAAA_5555_AAAA_0F0F_F0F0_1111_2222_3333;
        srch_x(dk, 0, 10, 7, 1, 0, 3, dk, 0); idle(12);
        chk_res("R10 write in cycle A seen", 7, 1, 7'd6);

        // R1 aborted second cycle
        cnt0 = ssv_cnt;
        srch_x(ent_d(0), 0, 11, 5, 0, 0, 0, '0, 1); idle(14);
        check("R1 aborted search gives no strobe", 144'(ssv_cnt), 144'(cnt0));
        chk_res("R1 aborted search leaves result", 5, 1, 7'd40);
        cmp_sel = 4'd11; #1;
        check("R1 aborted search leaves comparand", cmp_data, 144'(0));

        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule